// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a serial stereo audio stream into parallel samples. It runs entirely on the bit clock. On each rising bit clock edge it samples the serial data line and the left/right frame clock. A 2-bit format input picks how a channel word sits inside each half of the frame. The word can be left-aligned to the frame clock edge, delayed by one bit clock, or right-aligned against the next frame clock edge. All framings carry two's complement data, most significant bit first.

Each finished channel word comes out as a 24-bit sample, together with a one-cycle valid strobe and a flag that says whether the word belonged to the left channel. The 16-bit framings are left-aligned into the 24-bit result, and their low byte is zero. A consumer in the bit clock domain takes the sample while the strobe is high. Moving it to another clock domain is left to logic outside this block.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low at a rising edge, the outputs go to valid=0, sample=0 and left=0 at that edge.
- R2: With format 2'b10, the word starts with the bit sampled at the first rising edge that sees the new frame clock level. The first 24 bits of the half-frame form the sample, and a high frame clock means left.
- R3: With format 2'b11, the word starts one bit clock after the first rising edge that sees the new frame clock level. It runs up to and including the bit sampled at the first edge of the next level, and a low frame clock means left.
- R4: With format 2'b11 and 16 bit clocks per half-frame, the 16 received bits fill sample[23:8] and sample[7:0] is zero.
- R5: With format 2'b01, the sample is the last 24 bits sampled before the rising edge that sees the next frame clock level.
- R6: With format 2'b00, the sample is the last 16 bits sampled before the next frame clock level, placed in sample[23:8], with sample[7:0] zero.
- R7: Valid is high for exactly one cycle per completed channel word. It rises right after the rising edge at which the next channel word starts (for 2'b11, the edge one bit clock after the frame clock change is first seen), and it is never high in two cycles in a row.
- R8: A frame clock change is only recognised from the third rising edge after reset. The half-frame in progress at that first recognised change produces no valid.
- R9: In format 2'b10, bits beyond the 24th of a half-frame have no effect on the sample.
- R10: While valid is low, sample and left hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 2 | Framing: 00 16-bit right-aligned, 01 24-bit right-aligned, 10 24-bit left-aligned, 11 one-bit-delayed (I2S-style) |
| lrclk | input | 1 | Left/right frame clock |
| sdata | input | 1 | Serial data, MSB first |
| sample_o | output | 24 | Received two's complement sample |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| left_o | output | 1 | High when the sample belongs to the left channel |

## Verification
The in-line assertions watch, on every cycle, that the strobe is a single-cycle pulse tied to a recognised frame edge. They also check that the first recognised edge stays silent, that the outputs hold between strobes, and that the 16-bit right-aligned framing always gives a zero low byte. Only the bench scenarios can show that the right bits land in the right positions. That covers the one-bit delay and the inverted channel polarity of the I2S-style framing, the zero fill at 16 bit clocks per half-frame, the tail alignment of the right-aligned framings, and the truncation at 24 bits. The bench checks each of these against its behavioural model at several frame lengths.

// File: rtl/audrx_pkg.sv
// Package: shared framing codes and widths for the serial audio receiver.
// Assumes: the format code is held steady while a stream is received.
package audrx_pkg;
    typedef enum logic [1:0] {
        FMT_TAIL16 = 2'b00,
        FMT_TAIL24 = 2'b01,
        FMT_HEAD24 = 2'b10,
        FMT_DELAY1 = 2'b11
    } rx_fmt_e;

    localparam int unsigned RX_WORD_W  = 24;
    localparam int unsigned RX_SHORT_W = 16;
endpackage

// File: rtl/frame_edge_tracker.sv
// Module: frame_edge_tracker
// Finds the rising bit clock edge where a new channel word starts. For the
// one-bit-delayed framing it uses the frame clock delayed by one bit clock
// and inverted, so that every framing can treat "left" as a high level.
// Assumes: synchronous active-low reset; frame clock sampled on clk.
module frame_edge_tracker
    import audrx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rx_fmt_e fmt_i,
    input  logic    lrclk_i,
    output logic    edge_o,
    output logic    synced_o,
    output logic    chan_left_o
);
    localparam logic [1:0] WARM_DONE = 2'd2;

    logic       lr_dly;
    logic       lr_prev;
    logic       lr_cur;
    logic [1:0] warm_cnt;

    // Effective frame level: delayed and inverted for the one-bit-delayed framing
    always_comb lr_cur = (fmt_i == FMT_DELAY1) ? ~lr_dly : lrclk_i;

    // A word boundary is a change of the effective level once history is valid
    always_comb edge_o = (warm_cnt == WARM_DONE) && (lr_cur != lr_prev);

    // Channel of the word now ending is the level before the boundary
    always_comb chan_left_o = lr_prev;

    // Keeps the delayed level, previous level, warm-up count and sync flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_dly   <= 1'b0;
            lr_prev  <= 1'b0;
            warm_cnt <= '0;
            synced_o <= 1'b0;
        end else begin
            lr_dly  <= lrclk_i;
            lr_prev <= lr_cur;
            if (warm_cnt != WARM_DONE) warm_cnt <= warm_cnt + 2'd1;
            if (edge_o) synced_o <= 1'b1;
        end
    end

    // R8: no boundary is ever reported before two rising edges of history
    p_warm_before_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> $past(rst_n, 1) && $past(rst_n, 2));
endmodule

// File: rtl/word_collector.sv
// Module: word_collector
// Gathers serial bits two ways at once. A tail register shifts on every bit
// clock and so holds the most recent WORD_W bits. A head register places the
// bits that follow a word boundary from the MSB down and stops after WORD_W
// bits, leaving zeros where a short half-frame ends early.
// Assumes: edge_i marks the first bit of a new word.
module word_collector #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              edge_i,
    output logic [WORD_W-1:0] tail_word_o,
    output logic [WORD_W-1:0] head_word_o
);
    localparam int unsigned POS_W = $clog2(WORD_W + 1);
    localparam logic [POS_W-1:0] POS_FULL = POS_W'(WORD_W);

    logic [POS_W-1:0] head_pos;

    // Tail register: continuous MSB-first shift of every sampled bit
    always_ff @(posedge clk) begin
        if (!rst_n) tail_word_o <= '0;
        else        tail_word_o <= {tail_word_o[WORD_W-2:0], sdata_i};
    end

    // Head register: restarts at a boundary, fills downward, saturates when full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_word_o <= '0;
            head_pos    <= POS_FULL;
        end else if (edge_i) begin
            head_word_o <= {sdata_i, {(WORD_W-1){1'b0}}};
            head_pos    <= POS_W'(1);
        end else if (head_pos < POS_FULL) begin
            head_word_o[WORD_W-1-int'(head_pos)] <= sdata_i;
            head_pos <= head_pos + POS_W'(1);
        end
    end

    // R9: once WORD_W bits are taken, the head word does not change until a boundary
    p_head_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(head_pos) == POS_FULL && !$past(edge_i)) |-> $stable(head_word_o));
endmodule

// File: rtl/sample_emitter.sv
// Module: sample_emitter
// Picks the word that fits the selected framing at each boundary and
// registers it with a one-cycle strobe and the channel flag. The boundary
// that first synchronises the receiver is dropped.
// Assumes: fmt_i is steady; half-frames are longer than one bit clock.
module sample_emitter
    import audrx_pkg::*;
#(
    parameter int unsigned WORD_W  = 24,
    parameter int unsigned SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_fmt_e           fmt_i,
    input  logic              edge_i,
    input  logic              synced_i,
    input  logic              chan_left_i,
    input  logic [WORD_W-1:0] tail_word_i,
    input  logic [WORD_W-1:0] head_word_i,
    output logic [WORD_W-1:0] sample_o,
    output logic              valid_o,
    output logic              left_o
);
    localparam int unsigned PAD_W = WORD_W - SHORT_W;

    logic [WORD_W-1:0] pick_word;

    // Framing select: short tail is left-aligned with zero padding
    always_comb begin
        unique case (fmt_i)
            FMT_TAIL16: pick_word = {tail_word_i[SHORT_W-1:0], {PAD_W{1'b0}}};
            FMT_TAIL24: pick_word = tail_word_i;
            default:    pick_word = head_word_i;
        endcase
    end

    // Output register: load and strobe on a boundary once synchronised
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_o <= '0;
            valid_o  <= 1'b0;
            left_o   <= 1'b0;
        end else if (edge_i && synced_i) begin
            sample_o <= pick_word;
            valid_o  <= 1'b1;
            left_o   <= chan_left_i;
        end else begin
            valid_o  <= 1'b0;
        end
    end

    // R7: the strobe lasts a single cycle
    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R10: outputs hold between strobes
    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(sample_o) && $stable(left_o)));

    // R6: short right-aligned words leave the low byte zero
    p_short_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && fmt_i == FMT_TAIL16) |-> (sample_o[PAD_W-1:0] == '0));
endmodule

// File: rtl/serial_audio_rx.sv
// Module: serial_audio_rx (top)
// Serial stereo audio receiver with four runtime-selectable framings.
// Wires the boundary tracker, the bit collector and the output stage.
// Assumes: runs on the bit clock; synchronous active-low reset.
module serial_audio_rx
    import audrx_pkg::*;
#(
    parameter int unsigned WORD_W  = RX_WORD_W,
    parameter int unsigned SHORT_W = RX_SHORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              lrclk,
    input  logic              sdata,
    output logic [WORD_W-1:0] sample_o,
    output logic              valid_o,
    output logic              left_o
);
    rx_fmt_e           fmt;
    logic              edge_w;
    logic              synced_w;
    logic              chan_left_w;
    logic [WORD_W-1:0] tail_w;
    logic [WORD_W-1:0] head_w;

    // Format code cast to the shared enum
    always_comb fmt = rx_fmt_e'(fmt_sel);

    frame_edge_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt),
        .lrclk_i    (lrclk),
        .edge_o     (edge_w),
        .synced_o   (synced_w),
        .chan_left_o(chan_left_w)
    );

    word_collector #(.WORD_W(WORD_W)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata_i    (sdata),
        .edge_i     (edge_w),
        .tail_word_o(tail_w),
        .head_word_o(head_w)
    );

    sample_emitter #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt),
        .edge_i     (edge_w),
        .synced_i   (synced_w),
        .chan_left_i(chan_left_w),
        .tail_word_i(tail_w),
        .head_word_i(head_w),
        .sample_o   (sample_o),
        .valid_o    (valid_o),
        .left_o     (left_o)
    );

    // R8: the first recognised boundary produces no strobe
    p_first_edge_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_w && !synced_w) |=> !valid_o);

    // R7: every strobe follows a recognised boundary
    p_strobe_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(edge_w));
endmodule

// File: tb/serial_audio_rx_tb_top.sv
// Bench: behavioural model keeps the sampled history in queues and predicts
// the outputs after every rising edge; outputs are compared at each falling edge.
module serial_audio_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] sample_o;
    logic        valid_o;
    logic        left_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    bit          hist_lr[$];
    bit          hist_d[$];
    int          last_edge;
    logic [23:0] exp_sample;
    logic        exp_valid;
    logic        exp_left;
    string       tag;

    always #4 clk = ~clk;

    serial_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .lrclk(lrclk),
        .sdata(sdata), .sample_o(sample_o), .valid_o(valid_o), .left_o(left_o)
    );

    function automatic int eff_lr(int i);
        if (fmt_sel == 2'b11) return (i >= 1) ? int'(!hist_lr[i-1]) : -1;
        return (i >= 0) ? int'(hist_lr[i]) : -1;
    endfunction

    task automatic check(bit ok, string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(logic [1:0] f, string t);
        @(negedge clk);
        rst_n = 1'b0; fmt_sel = f; lrclk = 1'b0; sdata = 1'b0; tag = t;
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        check(valid_o == 1'b0 && left_o == 1'b0, "R1", {22'd0, valid_o, left_o}, 24'd0);
        check(sample_o == 24'd0, "R1", sample_o, 24'd0);
        rst_n = 1'b1;
        hist_lr.delete(); hist_d.delete();
        last_edge = -1;
        exp_sample = '0; exp_valid = 1'b0; exp_left = 1'b0;
    endtask

    // One bit clock: drive, predict, then compare after the rising edge
    task automatic step(bit lr, bit d);
        int n;
        logic [23:0] w;
        lrclk = lr; sdata = d;
        hist_lr.push_back(lr); hist_d.push_back(d);
        n = hist_lr.size() - 1;
        exp_valid = 1'b0;
        if (n >= 2 && eff_lr(n) != eff_lr(n-1)) begin
            if (last_edge >= 0) begin
                w = '0;
                if (fmt_sel[1]) begin
                    for (int i = 0; i < 24 && last_edge + i < n; i++) w[23-i] = hist_d[last_edge+i];
                end else begin
                    for (int i = 0; i < 24; i++) if (n - 1 - i >= 0) w[i] = hist_d[n-1-i];
                    if (fmt_sel == 2'b00) w = {w[15:0], 8'd0};
                end
                exp_valid = 1'b1; exp_sample = w; exp_left = eff_lr(n-1) == 1;
            end
            last_edge = n;
        end
        @(negedge clk);
        check(valid_o == exp_valid, "R7 R8 valid", {23'd0, valid_o}, {23'd0, exp_valid});
        if (exp_valid) begin
            check(sample_o == exp_sample, tag, sample_o, exp_sample);
            check(left_o == exp_left, {tag, " left"}, {23'd0, left_o}, {23'd0, exp_left});
        end else begin
            check(sample_o == exp_sample && left_o == exp_left, "R10 hold", sample_o, exp_sample);
        end
    endtask

    task automatic run_frames(int half, int frames);
        for (int f = 0; f < frames; f++)
            for (int h = 0; h < 2; h++)
                for (int b = 0; b < half; b++) step(h[0] ? 1'b0 : 1'b1, 1'($urandom));
    endtask

    initial begin
        do_reset(2'b10, "R2 R9 head24");
        run_frames(32, 6);
        run_frames(24, 4);
        do_reset(2'b11, "R3 delay1");
        run_frames(32, 6);
        run_frames(24, 3);
        do_reset(2'b11, "R4 delay1 16clk");
        run_frames(16, 8);
        do_reset(2'b01, "R5 tail24");
        run_frames(24, 6);
        run_frames(32, 4);
        do_reset(2'b00, "R6 tail16");
        run_frames(16, 6);
        run_frames(32, 4);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule